// File: doc/BRIEF.md
# Bid-Based Interrupt Arbiter

This block decides when a multi-channel serial controller interrupts its host, and which condition the host should serve first. Each of the channels has eight interrupt source types, and every source that is both pending and enabled places a numeric bid. The bid is built from a 4-bit FIFO level, the source type and the channel number, in that order of significance. The block raises its interrupt request while any bid is strictly greater than a threshold that software programs.

When the host acknowledges, the block stores the highest bid present at that moment in a current-interrupt register. This is not necessarily the bid that first crossed the threshold. A single read of that register tells the host the channel, the type and the level it should serve. The channel, type and level are also driven out on their own pins for vector generation.

Each channel has its own mask register, its own status register and its own mode register. Two source types follow FIFO request lines. The other six are sticky event flags that software clears by writing ones.

The ports are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_bid_arbiter`

## Requirements
- R1: After reset, `irq` and `cir_valid` are 0, every mask, mode and status register reads 0, the threshold reads all ones (0x3FF with the default parameters) and the current-interrupt register reads 0.
- R2: A source takes part in the arbitration only while both its status bit and its mask bit are 1. Source type t of channel c uses bit t of that channel's status and mask registers.
- R3: The bid is {level, type, channel}, with the level in the most significant bits. The level is the channel's transmit level for type 0 (transmit empty) and its receive level for type 1 (receive fill). Types 2 to 7 use level 0xF: 2 break change, 3 receive error, 4 pin change, 5 receive timeout, 6 flow-control character match, 7 address character match.
- R4: `irq` is 1 exactly when, at the previous clock edge, some participating bid was strictly greater than the threshold. A bid equal to the threshold does not raise `irq`.
- R5: A clock edge with `iack` high stores the largest participating bid, when it exceeds the threshold, into the current-interrupt register and sets `cir_valid`. The stored bid is the largest one present at that edge, even if a smaller bid raised the request first.
- R6: If no participating bid exceeds the threshold at an `iack` edge, `cir_valid` becomes 0 and the channel, type and level fields become 0.
- R7: The current-interrupt register and `cir_valid` keep their values between acknowledges, whatever the sources, masks or threshold do in the meantime.
- R8: Status bits 0 and 1 of channel c follow `fifo_req[2c]` (transmit empty request) and `fifo_req[2c+1]` (receive fill request) one clock later. Writes do not change these bits. Bits 2 to 7 are set by `evt_pulse[6c+t-2]` and cleared by writing 1 to the bit. When a set and a clear reach the same bit in the same cycle, the set wins.
- R9: A status read returns the raw status when bit 6 of the channel's mode register is 0, and the status ANDed with the mask when that bit is 1.
- R10: Register addresses with NUM_CH channels: the mask of channel c is at c, the status at NUM_CH+c, the mode at 2*NUM_CH+c, the threshold at 3*NUM_CH, and the current-interrupt register (read only) at 3*NUM_CH+1. Writes take effect at the clock edge on which `wr_en` is high, and reads are combinational.
- R11: A read of the current-interrupt register returns {valid, level, type, channel} in the bits from BID_W down to 0, with the upper bits 0. The same fields drive `cir_valid`, `cir_level`, `cir_type` and `cir_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_req | input | 2*NUM_CH | Per channel: bit 0 is the transmit-empty request, bit 1 is the receive-fill request |
| tx_lvl | input | NUM_CH*LVL_W | Per-channel transmit empty level |
| rx_lvl | input | NUM_CH*LVL_W | Per-channel receive fill level |
| evt_pulse | input | 6*NUM_CH | Per-channel one-cycle event pulses for source types 2 to 7 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| iack | input | 1 | Interrupt acknowledge strobe |
| irq | output | 1 | Interrupt request |
| cir_valid | output | 1 | Current-interrupt register holds a winner |
| cir_chan | output | CH_W | Channel of the captured winner |
| cir_type | output | 3 | Source type of the captured winner |
| cir_level | output | LVL_W | Level of the captured winner |

## Verification
The bench builds the block with the default parameters: eight channels and a 4-bit level. This gives the full 64-source arbitration and a 10-bit bid. With these values the channel index reaches 7 and the level reaches 0xF, so fixed-level event bids can be made to compete against FIFO bids of every size. The directed scenarios place the threshold exactly on a bid and one below it. They also acknowledge while several sources on different channels compete, and change a channel's levels between acknowledges so that a different type of the same channel wins.

// File: rtl/irqbid_pkg.sv
package irqbid_pkg;
  localparam int TY_W          = 3;
  localparam int NUM_TYPE      = 8;
  localparam int NUM_FIFO_TYPE = 2;
  localparam int NUM_EVT       = NUM_TYPE - NUM_FIFO_TYPE;
  localparam int MODE_MASKRD   = 6;

  typedef enum logic [TY_W-1:0] {
    SRC_TX_EMPTY = 3'd0,
    SRC_RX_FILL  = 3'd1,
    SRC_BRK_CHG  = 3'd2,
    SRC_RX_ERR   = 3'd3,
    SRC_PIN_CHG  = 3'd4,
    SRC_RX_TMO   = 3'd5,
    SRC_FLOW_CH  = 3'd6,
    SRC_ADDR_CH  = 3'd7
  } src_type_e;
endpackage

// File: rtl/irqbid_chan.sv
module irqbid_chan
  import irqbid_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fifo_req,
  input  logic [LVL_W-1:0]    tx_lvl,
  input  logic [LVL_W-1:0]    rx_lvl,
  input  logic [NUM_EVT-1:0]  evt_pulse,
  input  logic                mask_we,
  input  logic                stat_we,
  input  logic                mode_we,
  input  logic [NUM_TYPE-1:0] wdata,
  output logic [NUM_TYPE-1:0] stat_q,
  output logic [NUM_TYPE-1:0] mask_q,
  output logic [NUM_TYPE-1:0] mode_q,
  output logic [NUM_TYPE-1:0] part,
  output logic [LVL_W-1:0]    tx_lvl_q,
  output logic [LVL_W-1:0]    rx_lvl_q
);
  logic [NUM_EVT-1:0] clr_bits;

  assign clr_bits = stat_we ? wdata[NUM_TYPE-1:NUM_FIFO_TYPE] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= '0;
      mask_q   <= '0;
      mode_q   <= '0;
      tx_lvl_q <= '0;
      rx_lvl_q <= '0;
    end else begin
      stat_q[NUM_FIFO_TYPE-1:0]        <= fifo_req;
      // a set and a clear in the same cycle: the set wins
      stat_q[NUM_TYPE-1:NUM_FIFO_TYPE] <= evt_pulse |
                                          (stat_q[NUM_TYPE-1:NUM_FIFO_TYPE] & ~clr_bits);
      tx_lvl_q <= tx_lvl;
      rx_lvl_q <= rx_lvl;
      if (mask_we) mask_q <= wdata;
      if (mode_we) mode_q <= wdata;
    end
  end

  assign part = stat_q & mask_q;
endmodule

// File: rtl/irqbid_maxtree.sv
module irqbid_maxtree #(
  parameter int N     = 64,
  parameter int BID_W = 10
) (
  input  logic [N-1:0]       valid,
  input  logic [N*BID_W-1:0] bids,
  output logic               win_valid,
  output logic [BID_W-1:0]   win_bid
);
  localparam int NODES = 2 * N - 1;

  logic [NODES-1:0] nv;
  logic [BID_W-1:0] nb [NODES];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign nv[N-1+i] = valid[i];
    assign nb[N-1+i] = bids[i*BID_W +: BID_W];
  end

  for (genvar j = 0; j < N - 1; j++) begin : g_node
    logic take_l;
    assign take_l = nv[2*j+1] && (!nv[2*j+2] || (nb[2*j+1] > nb[2*j+2]));
    assign nv[j]  = nv[2*j+1] | nv[2*j+2];
    assign nb[j]  = take_l ? nb[2*j+1] : nb[2*j+2];
  end

  assign win_valid = nv[0];
  assign win_bid   = nb[0];
endmodule

// File: rtl/irqbid_capture.sv
module irqbid_capture #(
  parameter int BID_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  input  logic [BID_W-1:0] win_bid,
  input  logic [BID_W-1:0] thr,
  input  logic             iack,
  output logic             irq,
  output logic             cir_valid,
  output logic [BID_W-1:0] cir_bid
);
  logic above;

  assign above = win_valid && (win_bid > thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      cir_valid <= 1'b0;
      cir_bid   <= '0;
    end else begin
      irq <= above;
      if (iack) begin
        cir_valid <= above;
        cir_bid   <= above ? win_bid : '0;
      end
    end
  end
endmodule

// File: rtl/irq_bid_arbiter.sv
module irq_bid_arbiter
  import irqbid_pkg::*;
#(
  parameter  int NUM_CH = 8,
  parameter  int LVL_W  = 4,
  parameter  int DATA_W = 16,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = $clog2(3 * NUM_CH + 2)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2*NUM_CH-1:0]        fifo_req,
  input  logic [NUM_CH*LVL_W-1:0]    tx_lvl,
  input  logic [NUM_CH*LVL_W-1:0]    rx_lvl,
  input  logic [NUM_EVT*NUM_CH-1:0]  evt_pulse,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       iack,
  output logic                       irq,
  output logic                       cir_valid,
  output logic [CH_W-1:0]            cir_chan,
  output logic [TY_W-1:0]            cir_type,
  output logic [LVL_W-1:0]           cir_level
);
  localparam int NUM_SRC   = NUM_CH * NUM_TYPE;
  localparam int BID_W     = LVL_W + TY_W + CH_W;
  localparam int MASK_BASE = 0;
  localparam int STAT_BASE = NUM_CH;
  localparam int MODE_BASE = 2 * NUM_CH;
  localparam int THR_ADDR  = 3 * NUM_CH;
  localparam int CIR_ADDR  = 3 * NUM_CH + 1;

  logic [NUM_CH-1:0][NUM_TYPE-1:0] stat, mask, mode, part;
  logic [LVL_W-1:0]                txq [NUM_CH];
  logic [LVL_W-1:0]                rxq [NUM_CH];
  logic [NUM_SRC-1:0]              part_flat;
  logic [NUM_SRC*BID_W-1:0]        bid_flat;
  logic                            win_valid;
  logic [BID_W-1:0]                win_bid;
  logic [BID_W-1:0]                thr_q;
  logic [BID_W-1:0]                cir_bid_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic mwe, swe, dwe;
    assign mwe = wr_en && (wr_addr == ADDR_W'(MASK_BASE + c));
    assign swe = wr_en && (wr_addr == ADDR_W'(STAT_BASE + c));
    assign dwe = wr_en && (wr_addr == ADDR_W'(MODE_BASE + c));

    irqbid_chan #(.LVL_W(LVL_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .fifo_req (fifo_req[2*c +: 2]),
      .tx_lvl   (tx_lvl[c*LVL_W +: LVL_W]),
      .rx_lvl   (rx_lvl[c*LVL_W +: LVL_W]),
      .evt_pulse(evt_pulse[c*NUM_EVT +: NUM_EVT]),
      .mask_we  (mwe),
      .stat_we  (swe),
      .mode_we  (dwe),
      .wdata    (wr_data[NUM_TYPE-1:0]),
      .stat_q   (stat[c]),
      .mask_q   (mask[c]),
      .mode_q   (mode[c]),
      .part     (part[c]),
      .tx_lvl_q (txq[c]),
      .rx_lvl_q (rxq[c])
    );

    for (genvar t = 0; t < NUM_TYPE; t++) begin : g_ty
      logic [LVL_W-1:0] lvl;
      if (t == int'(SRC_TX_EMPTY)) begin : g_tx
        assign lvl = txq[c];
      end else if (t == int'(SRC_RX_FILL)) begin : g_rx
        assign lvl = rxq[c];
      end else begin : g_evt
        assign lvl = '1;
      end
      assign bid_flat[(c*NUM_TYPE+t)*BID_W +: BID_W] = {lvl, TY_W'(t), CH_W'(c)};
    end
  end

  assign part_flat = part;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        thr_q <= '1;
    else if (wr_en && wr_addr == ADDR_W'(THR_ADDR))    thr_q <= wr_data[BID_W-1:0];
  end

  irqbid_maxtree #(.N(NUM_SRC), .BID_W(BID_W)) u_max (
    .valid    (part_flat),
    .bids     (bid_flat),
    .win_valid(win_valid),
    .win_bid  (win_bid)
  );

  irqbid_capture #(.BID_W(BID_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_valid(win_valid),
    .win_bid  (win_bid),
    .thr      (thr_q),
    .iack     (iack),
    .irq      (irq),
    .cir_valid(cir_valid),
    .cir_bid  (cir_bid_q)
  );

  assign cir_chan  = cir_bid_q[CH_W-1:0];
  assign cir_type  = cir_bid_q[CH_W +: TY_W];
  assign cir_level = cir_bid_q[BID_W-1 -: LVL_W];

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(MASK_BASE + c)) rd_data[NUM_TYPE-1:0] = mask[c];
      if (rd_addr == ADDR_W'(MODE_BASE + c)) rd_data[NUM_TYPE-1:0] = mode[c];
      if (rd_addr == ADDR_W'(STAT_BASE + c))
        rd_data[NUM_TYPE-1:0] = mode[c][MODE_MASKRD] ? (stat[c] & mask[c]) : stat[c];
    end
    if (rd_addr == ADDR_W'(THR_ADDR)) rd_data[BID_W-1:0] = thr_q;
    if (rd_addr == ADDR_W'(CIR_ADDR)) rd_data[BID_W:0]   = {cir_valid, cir_bid_q};
  end
endmodule

// File: rtl/irqbid_chk.sv
module irqbid_chk #(
  parameter int NUM_SRC = 64,
  parameter int BID_W   = 10,
  parameter int CH_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iack,
  input logic               irq,
  input logic               cir_valid,
  input logic [BID_W-1:0]   cir_bid,
  input logic               win_valid,
  input logic [BID_W-1:0]   win_bid,
  input logic [BID_W-1:0]   thr,
  input logic [NUM_SRC-1:0] part
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic             armed;
  logic             above;
  logic [IDX_W-1:0] win_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign above   = win_valid && (win_bid > thr);
  assign win_idx = IDX_W'({win_bid[CH_W-1:0], win_bid[CH_W +: 3]});

  // R2
  winner_participates_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    win_valid |-> part[win_idx]);

  // R4
  irq_needs_bid_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    irq |-> $past(above));

  // R4
  irq_follows_bid_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    above |=> irq);

  // R5
  capture_highest_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (iack && above) |=> (cir_valid && cir_bid == $past(win_bid)));

  // R6
  capture_empty_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (iack && !above) |=> (!cir_valid && cir_bid == '0));

  // R7
  cir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !iack |=> ($stable(cir_valid) && $stable(cir_bid)));
endmodule

bind irq_bid_arbiter irqbid_chk #(
  .NUM_SRC(NUM_SRC),
  .BID_W  (BID_W),
  .CH_W   (CH_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iack     (iack),
  .irq      (irq),
  .cir_valid(cir_valid),
  .cir_bid  (cir_bid_q),
  .win_valid(win_valid),
  .win_bid  (win_bid),
  .thr      (thr_q),
  .part     (part_flat)
);

// File: tb/sim_irq_bid_arbiter.sv
`timescale 1ns/1ps
module sim_irq_bid_arbiter;
  localparam int NCH = 8;
  localparam int LW  = 4;
  localparam int THR = 24;
  localparam int CIR = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] fifo_req = '0;
  logic [31:0] tx_lvl = '0;
  logic [31:0] rx_lvl = '0;
  logic [47:0] evt_pulse = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        iack = 1'b0;
  logic        irq, cir_valid;
  logic [2:0]  cir_chan, cir_type;
  logic [3:0]  cir_level;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_bid_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .fifo_req(fifo_req), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
    .evt_pulse(evt_pulse), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .iack(iack), .irq(irq), .cir_valid(cir_valid),
    .cir_chan(cir_chan), .cir_type(cir_type), .cir_level(cir_level)
  );

  function automatic int bid(int lvl, int ty, int ch);
    return (lvl << 6) | (ty << 3) | ch;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    fifo_req = '0; tx_lvl = '0; rx_lvl = '0; evt_pulse = '0;
    wr_en = 1'b0; iack = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
    @(posedge clk);
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 5'(a);
    #1 d = int'(rd_data);
  endtask

  task automatic pulse_evt(input int ch, input int ty);
    evt_pulse[ch*6 + ty - 2] = 1'b1;
    @(posedge clk);
    @(negedge clk) evt_pulse = '0;
  endtask

  task automatic ack();
    iack = 1'b1;
    @(posedge clk);
    @(negedge clk) iack = 1'b0;
  endtask

  task automatic chk_cir(input string req, input int expv, input int expb);
    int got;
    got = {cir_valid, cir_level, cir_type, cir_chan};
    chk(got == ((expv << 10) | expb), req, got, (expv << 10) | expb);
  endtask

  task automatic t_reset();
    int d;
    do_reset();
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(cir_valid == 1'b0, "R1 cir_valid", cir_valid, 0);
    rd(3, d);        chk(d == 0, "R1 mask", d, 0);
    rd(NCH + 5, d);  chk(d == 0, "R1 status", d, 0);
    rd(THR, d);      chk(d == 'h3FF, "R1/R10 threshold", d, 'h3FF);
    rd(CIR, d);      chk(d == 0, "R1/R11 cir read", d, 0);
  endtask

  task automatic t_mask_gate();
    do_reset();
    wr(THR, 0);
    fifo_req[3*2] = 1'b1; tx_lvl[3*LW +: LW] = 4'd5;
    settle();
    chk(irq == 1'b0, "R2 masked source", irq, 0);
    wr(3, 'h01);
    settle();
    chk(irq == 1'b1, "R2 unmasked source", irq, 1);
    wr(3, 'h02);
    settle();
    chk(irq == 1'b0, "R2 other mask bit", irq, 0);
  endtask

  task automatic t_threshold();
    do_reset();
    fifo_req[3*2] = 1'b1; tx_lvl[3*LW +: LW] = 4'd5;
    wr(3, 'h01);
    wr(THR, bid(5, 0, 3));
    settle();
    chk(irq == 1'b0, "R4 bid equal to threshold", irq, 0);
    wr(THR, bid(5, 0, 3) - 1);
    settle();
    chk(irq == 1'b1, "R4 bid above threshold", irq, 1);
    ack();
    chk_cir("R3/R5 tx level capture", 1, bid(5, 0, 3));
  endtask

  task automatic t_capture_highest();
    int d;
    do_reset();
    wr(THR, 0);
    fifo_req[1*2+1] = 1'b1; rx_lvl[1*LW +: LW] = 4'd2;
    wr(1, 'h02);
    settle();
    chk(irq == 1'b1, "R4 low bid raises irq", irq, 1);
    wr(0, 'h04); wr(6, 'h08);
    pulse_evt(0, 2); pulse_evt(6, 3);
    settle();
    ack();
    chk_cir("R5 highest bid captured", 1, bid(15, 3, 6));
    rd(CIR, d);
    chk(d == ('h400 | bid(15, 3, 6)), "R11 cir read format", d, 'h400 | bid(15, 3, 6));
    wr(NCH + 6, 'h08);
    settle();
    ack();
    chk_cir("R5/R8 next winner after clear", 1, bid(15, 2, 0));
  endtask

  task automatic t_no_winner();
    do_reset();
    wr(THR, 0);
    fifo_req[2*2] = 1'b1; tx_lvl[2*LW +: LW] = 4'd9;
    wr(2, 'h01);
    settle();
    ack();
    chk_cir("R5 capture before empty", 1, bid(9, 0, 2));
    wr(THR, 'h3FF);
    settle();
    ack();
    chk_cir("R6 no bid above threshold", 0, 0);
  endtask

  task automatic t_hold();
    do_reset();
    wr(THR, 0);
    fifo_req[4*2+1] = 1'b1; rx_lvl[4*LW +: LW] = 4'd7;
    wr(4, 'h02);
    settle();
    ack();
    chk_cir("R7 initial capture", 1, bid(7, 1, 4));
    fifo_req = '0; rx_lvl = '0;
    wr(5, 'hFF); pulse_evt(5, 7);
    repeat (5) @(negedge clk);
    chk_cir("R7 hold between acks", 1, bid(7, 1, 4));
    chk(irq == 1'b1, "R4 irq from new source", irq, 1);
  endtask

  task automatic t_sticky();
    int d;
    do_reset();
    fifo_req[2*2] = 1'b1;
    evt_pulse[2*6 + 7 - 2] = 1'b1;
    wr(NCH + 2, 'h80);
    evt_pulse = '0;
    settle();
    rd(NCH + 2, d); chk(d == 'h81, "R8 set beats clear", d, 'h81);
    wr(NCH + 2, 'h83);
    rd(NCH + 2, d); chk(d == 'h01, "R8 clear event, fifo bit kept", d, 'h01);
    fifo_req = '0;
    settle();
    rd(NCH + 2, d); chk(d == 'h00, "R8 fifo bit follows input", d, 0);
  endtask

  task automatic t_read_mode();
    int d;
    do_reset();
    pulse_evt(4, 4); pulse_evt(4, 5);
    wr(4, 'h10);
    rd(NCH + 4, d); chk(d == 'h30, "R9 raw status read", d, 'h30);
    wr(2*NCH + 4, 'h40);
    rd(NCH + 4, d); chk(d == 'h10, "R9 masked status read", d, 'h10);
    rd(2*NCH + 4, d); chk(d == 'h40, "R10 mode readback", d, 'h40);
  endtask

  task automatic t_levels();
    do_reset();
    wr(THR, 0);
    fifo_req[7*2 +: 2] = 2'b11;
    tx_lvl[7*LW +: LW] = 4'hA; rx_lvl[7*LW +: LW] = 4'hC;
    wr(7, 'h03);
    settle();
    ack();
    chk_cir("R3 rx level outranks tx", 1, bid(12, 1, 7));
    rx_lvl[7*LW +: LW] = 4'h3;
    settle();
    ack();
    chk_cir("R3 tx level wins after rx drops", 1, bid(10, 0, 7));
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mask_gate();
    t_threshold();
    t_capture_highest();
    t_no_winner();
    t_hold();
    t_sticky();
    t_read_mode();
    t_levels();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule